// File: doc/BRIEF.md
# Microscaling FP8 Block Quantizer

The block takes a stream of single-precision floating-point values and packs them into groups of 32 consecutive elements. For each group it finds the largest magnitude and derives a shared power-of-two scale that is stored as one unsigned exponent byte with bias 127. The byte stands for 2^(byte-127), and it is chosen so that the largest element, once divided by the scale, still fits the E4M3 range of ±448. Every element is then divided by that scale and rounded to an 8-bit E4M3 code.

Input and output are valid/ready streams. The input carries one 32-bit word per beat, and the producer marks the 32nd word of each group with a last flag. The output carries the 32 codes in arrival order, followed by the scale byte, which is tagged by a scale flag. The block holds one group at a time. It accepts input while it collects a group, and it emits output while it drains that group.

Top module: `mx_block_quant`

## Requirements
- R1: After reset the block accepts input (`in_ready` high). After the 32nd accepted word `in_ready` goes low and `out_valid` goes high in the next cycle. `in_ready` and `out_valid` are never high together. `in_ready` returns in the cycle after the scale byte is taken. The producer raises `in_last` on the 32nd word of each group.
- R2: A group is emitted as 33 bytes. First come the 32 codes, in the order the words arrived, with `out_scale` low. Then comes the scale byte with `out_scale` high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_scale` hold their values.
- R3: For a finite, nonzero group maximum with biased exponent E and fraction F (23 bits), the scale byte is E-8. It is E-7 when F is above 0x600000. The result is clamped to 0 when it would be negative. This equals the exponent of amax/448, rounded up whenever that quotient is not an exact power of two.
- R4: A group whose elements are all zero or subnormal emits scale byte 0x00, and every code in it is 0x00.
- R5: Each finite element x is converted to the E4M3 code of x/2^(scale-127), rounded to nearest with ties to even. Bit 7 is the sign, bits 6:3 are the exponent with bias 7, and bits 2:0 are the mantissa. An exponent field of 0 encodes mantissa/8·2^-6.
- R6: A scaled magnitude above 448 becomes magnitude code 0x7E. When the scale byte is not 0xFF, the magnitude code 0x7F is never emitted. A group maximum of 447.99 rounds to code 0x7E.
- R7: If any element of a group is NaN or infinite (exponent field 0xFF), the scale byte is 0xFF and every code of that group is 0x7F.
- R8: An element whose converted magnitude is zero emits 0x00, never a negative zero. Subnormal input words count as zero, both for the maximum and for conversion.
- R9: A synchronous active-low reset, also one applied in the middle of a group, leaves `out_valid` low and `in_ready` high, with no bytes of the interrupted group pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block is collecting and takes the word |
| in_data | input | 32 | Single-precision input element |
| in_last | input | 1 | Marks the 32nd word of a group |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | E4M3 code or scale byte |
| out_scale | output | 1 | High when `out_data` is the scale byte |

## Verification
The first code of a group is due one cycle after the rising edge that takes the 32nd word. Each later byte is due one cycle after the edge that took the byte before it, and `in_ready` comes back one cycle after the scale byte is taken. There is no other register on the path, so codes and the scale are combinational from the held group.

The bench samples on the falling edge. It checks the output byte before it adds any word taken in that cycle to its model. This way an expected byte can only appear in the cycle after the edge that completes the group. A stalled byte is compared again on every cycle it stays valid.

// File: rtl/mx_pkg.sv
// Shared constants for the microscaling FP8 quantizer: single-precision field
// layout, the E4M3 code limits and the fixed relation 448 = 1.75 * 2^8.
package mx_pkg;
    localparam int F32_W       = 32;
    localparam int F32_MW      = 23;
    localparam logic [7:0]  F32_EXP_SPECIAL = 8'hFF;
    // 448 = 1.75 * 2^8: quotient exponent offset and significand threshold
    localparam logic [9:0]  QUOT_EXP_OFS    = 10'd8;
    localparam logic [22:0] SIG_1P75        = 23'h600000;
    localparam logic [6:0]  E4_MAX_MAG      = 7'h7E;
    localparam logic [7:0]  E4_NAN_CODE     = 8'h7F;
    localparam logic [7:0]  SCALE_NAN       = 8'hFF;
    typedef logic [F32_W-1:0] f32_t;
endpackage

// File: rtl/mx_amax_track.sv
// Tracks the largest magnitude of the group as words arrive, and flags
// non-finite words. Assumes subnormal words count as zero. The first word
// of a group overwrites the previous state, so no clear cycle is needed.
module mx_amax_track
    import mx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        first,
    input  f32_t        elem,
    output logic [30:0] amax,
    output logic        nonfinite
);
    logic [30:0] mag;
    logic        is_special;

    // Magnitude with subnormals flushed, plus the special-exponent test
    always_comb begin
        mag        = (elem[30:23] == 8'd0) ? 31'd0 : elem[30:0];
        is_special = (elem[30:23] == F32_EXP_SPECIAL);
    end

    // Running maximum over the group, restarted on its first word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amax      <= '0;
            nonfinite <= 1'b0;
        end else if (take) begin
            if (first) begin
                amax      <= mag;
                nonfinite <= is_special;
            end else begin
                if (mag > amax) amax <= mag;
                nonfinite <= nonfinite | is_special;
            end
        end
    end
endmodule

// File: rtl/mx_scale_calc.sv
// Derives the exponent-only scale byte from the group maximum without a
// divider. Because 448 = 1.75*2^8, the rounded-up exponent of amax/448 is
// E-8, or E-7 when the fraction exceeds that of 1.75. Negative results
// clamp to 0. Assumes amax already has subnormals flushed.
module mx_scale_calc
    import mx_pkg::*;
(
    input  logic [30:0] amax,
    input  logic        nonfinite,
    output logic [7:0]  scale
);
    logic [9:0] t;
    logic       up;

    // Exponent arithmetic with round-up and clamp
    always_comb begin
        up = (amax[22:0] > SIG_1P75);
        t  = {2'b00, amax[30:23]} + {9'd0, up} - QUOT_EXP_OFS;
        if (nonfinite)                scale = SCALE_NAN;
        else if (amax[30:23] == 8'd0) scale = 8'd0;
        else if (t[9])                scale = 8'd0;
        else                          scale = 8'(t);
    end
endmodule

// File: rtl/mx_e4m3_conv.sv
// Converts one single-precision word, divided by 2^(scale-127), to an E4M3
// code with round-to-nearest-even and saturation at 448. Zero results give
// +0. Assumes the scale is the group's and that special words mark the
// group non-finite, in which case the NaN code is produced.
module mx_e4m3_conv
    import mx_pkg::*;
(
    input  f32_t       elem,
    input  logic [7:0] scale,
    input  logic       nonfinite,
    output logic [7:0] code
);
    logic [7:0]         e;
    logic [22:0]        m;
    logic               s;
    logic signed [10:0] ey;
    logic signed [10:0] sht;
    logic [4:0]         sh;
    logic [23:0]        sig, q, lowmask;
    logic [7:0]         sum8;
    logic [6:0]         mag;
    logic               g, st, rnd;

    // Normal and subnormal rounding paths, then sign and special handling
    always_comb begin
        e       = elem[30:23];
        m       = elem[F32_MW-1:0];
        s       = elem[31];
        sig     = {1'b1, m};
        ey      = $signed({3'b000, e}) - $signed({3'b000, scale});
        sht     = 11'sd14 - ey;
        sh      = 5'(sht);
        q       = '0;
        lowmask = '0;
        sum8    = '0;
        g       = 1'b0;
        st      = 1'b0;
        rnd     = 1'b0;
        mag     = '0;
        if (e == 8'd0) begin
            mag = '0;
        end else if (ey > 11'sd8) begin
            mag = E4_MAX_MAG;
        end else if (ey >= -11'sd6) begin
            g    = m[19];
            st   = |m[18:0];
            rnd  = g & (st | m[20]);
            sum8 = {1'b0, 4'(ey + 11'sd7), m[22:20]} + {7'd0, rnd};
            mag  = (sum8 > {1'b0, E4_MAX_MAG}) ? E4_MAX_MAG : sum8[6:0];
        end else if (sht < 11'sd25) begin
            q       = sig >> sh;
            g       = sig[sh - 5'd1];
            lowmask = (24'd1 << (sh - 5'd1)) - 24'd1;
            st      = |(sig & lowmask);
            rnd     = g & (st | q[0]);
            mag     = 7'(q + {23'd0, rnd});
        end
        if (nonfinite)        code = E4_NAN_CODE;
        else if (mag == 7'd0) code = 8'd0;
        else                  code = {s, mag};
    end
endmodule

// File: rtl/mx_block_quant.sv
// Microscaling FP8 block quantizer. Collects GROUP words into a buffer while
// tracking the maximum, then emits GROUP E4M3 codes and the scale byte.
// Assumes one group in flight: input is refused while a group drains.
module mx_block_quant
    import mx_pkg::*;
#(
    parameter int GROUP = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic        in_last,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_scale
);
    localparam int IW = $clog2(GROUP);
    localparam int CW = $clog2(GROUP + 1);

    logic          emitting;
    logic [CW-1:0] cnt;
    f32_t          grp_buf [GROUP];
    logic          in_take, last_beat;
    logic [30:0]   amax;
    logic          nonfinite;
    logic [7:0]    grp_scale;
    logic [7:0]    code;

    // Handshake decode
    always_comb begin
        in_take   = in_valid && !emitting;
        last_beat = (cnt == CW'(GROUP - 1));
        in_ready  = !emitting;
        out_valid = emitting;
        out_scale = emitting && (cnt == CW'(GROUP));
        out_data  = out_scale ? grp_scale : code;
    end

    // One register per buffer slot, written when its index arrives
    for (genvar i = 0; i < GROUP; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (in_take && (cnt == CW'(i))) grp_buf[i] <= in_data;
        end
    end

    // Collect/emit sequencing with a shared index counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emitting <= 1'b0;
            cnt      <= '0;
        end else if (!emitting) begin
            if (in_valid) begin
                if (last_beat) begin
                    emitting <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end else if (out_ready) begin
            if (cnt == CW'(GROUP)) begin
                emitting <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    mx_amax_track u_amax (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (in_take),
        .first     (cnt == '0),
        .elem      (in_data),
        .amax      (amax),
        .nonfinite (nonfinite)
    );

    mx_scale_calc u_scale (
        .amax      (amax),
        .nonfinite (nonfinite),
        .scale     (grp_scale)
    );

    mx_e4m3_conv u_conv (
        .elem      (grp_buf[cnt[IW-1:0]]),
        .scale     (grp_scale),
        .nonfinite (nonfinite),
        .code      (code)
    );
endmodule

// File: rtl/mx_block_quant_checks.sv
// Protocol and encoding properties of the quantizer, bound to the top.
// Assumes the internal index and scale byte are connected by the bind.
module mx_block_quant_checks #(
    parameter int GROUP = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_last,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_scale,
    input logic [CW-1:0] cnt,
    input logic [7:0]    grp_scale
);
    // R1: collecting and emitting are exclusive and one is always active
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready ^ out_valid);

    // R1: the last flag accompanies the final word of a group
    a_r1_last_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |-> (cnt == CW'(GROUP - 1)));

    // R1: taking the final word starts emission with a code
    a_r1_close: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cnt == CW'(GROUP - 1)) |=> (out_valid && !out_scale));

    // R1: input resumes right after the scale byte is taken
    a_r1_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_scale) |=> in_ready);

    // R2: a stalled byte is held
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_scale)));

    // R6: NaN code only in a non-finite group
    a_r6_no_nan_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_scale && out_data[6:0] == 7'h7F) |-> (grp_scale == 8'hFF));
endmodule

bind mx_block_quant mx_block_quant_checks #(.GROUP(GROUP), .CW(CW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_scale (out_scale),
    .cnt       (cnt),
    .grp_scale (grp_scale)
);

// File: tb/mx_block_quant_test.sv
// Bench: behavioural model with real arithmetic, compared on every falling edge.
module mx_block_quant_test;
    localparam int CLK_PERIOD = 10;
    localparam int NGRP       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_scale;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int stall_pct = 0;
    string cur_tag = "R5";

    logic [31:0] blk [NGRP];
    logic [31:0] model_in [$];
    logic [7:0]  exp_q [$];
    bit          exp_sc [$];
    string       exp_tag [$];

    mx_block_quant uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_scale(out_scale)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic real pow2(input int k);
        return 2.0 ** real'(k);
    endfunction

    function automatic real f32_mag(input logic [31:0] b);
        if (b[30:23] == 8'd0) return 0.0;
        return (1.0 + real'(b[22:0]) / pow2(23)) * pow2(int'(b[30:23]) - 127);
    endfunction

    function automatic real e4m3_mag(input int c);
        int f = c / 8;
        int m = c % 8;
        if (f == 0) return (real'(m) / 8.0) * pow2(-6);
        return (1.0 + real'(m) / 8.0) * pow2(f - 7);
    endfunction

    function automatic int ref_scale(input real amax);
        real q;
        int k = 0;
        int s;
        if (amax == 0.0) return 0;
        q = amax / 448.0;
        while (q >= pow2(k + 1)) k++;
        while (q < pow2(k)) k--;
        s = k + 127 + ((q != pow2(k)) ? 1 : 0);
        if (s < 0) s = 0;
        return s;
    endfunction

    function automatic logic [7:0] ref_code(input logic [31:0] b, input int s);
        real y, d, bd;
        int best = 0;
        if (b[30:23] == 8'd0) return 8'h00;
        y = f32_mag(b) / pow2(s - 127);
        if (y > 448.0) y = 448.0;
        bd = 1.0e300;
        for (int c = 0; c < 127; c++) begin
            d = y - e4m3_mag(c);
            if (d < 0.0) d = -d;
            if (d < bd) begin bd = d; best = c; end
            else if (d == bd && (c % 2 == 0)) best = c;
        end
        if (best == 0) return 8'h00;
        return {b[31], 7'(best)};
    endfunction

    task automatic model_group();
        bit nf = 1'b0;
        real amax = 0.0;
        int s;
        for (int i = 0; i < NGRP; i++) begin
            if (model_in[i][30:23] == 8'hFF) nf = 1'b1;
            else if (f32_mag(model_in[i]) > amax) amax = f32_mag(model_in[i]);
        end
        if (nf) begin
            for (int i = 0; i < NGRP; i++) begin
                exp_q.push_back(8'h7F); exp_sc.push_back(1'b0); exp_tag.push_back("R7");
            end
            exp_q.push_back(8'hFF); exp_sc.push_back(1'b1); exp_tag.push_back("R7");
        end else begin
            s = ref_scale(amax);
            for (int i = 0; i < NGRP; i++) begin
                exp_q.push_back(ref_code(model_in[i], s));
                exp_sc.push_back(1'b0);
                exp_tag.push_back(amax == 0.0 ? "R4" : cur_tag);
            end
            exp_q.push_back(8'(s)); exp_sc.push_back(1'b1);
            exp_tag.push_back(amax == 0.0 ? "R4" : "R3");
        end
        model_in.delete();
    endtask

    // Falling-edge monitor: outputs against the model first, then inputs into it
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual cycles=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
        if (!rst_n) begin
            model_in.delete(); exp_q.delete(); exp_sc.delete(); exp_tag.delete();
        end else begin
            check(out_valid == (exp_q.size() > 0), "R1 out_valid", 32'(out_valid), 32'(exp_q.size() > 0));
            check(in_ready == (exp_q.size() == 0), "R1 in_ready", 32'(in_ready), 32'(exp_q.size() == 0));
            if (out_valid && exp_q.size() > 0) begin
                check(out_data == exp_q[0], exp_tag[0], 32'(out_data), 32'(exp_q[0]));
                check(out_scale == exp_sc[0], "R2 out_scale", 32'(out_scale), 32'(exp_sc[0]));
                if (out_ready) begin
                    void'(exp_q.pop_front()); void'(exp_sc.pop_front()); void'(exp_tag.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                model_in.push_back(in_data);
                if (model_in.size() == NGRP) model_group();
            end
        end
    end

    // Consumer back-pressure, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        out_ready = ($urandom_range(99) >= stall_pct);
    end

    function automatic logic [31:0] mkf(input bit s, input int e, input logic [22:0] m);
        return {s, 8'(e), m};
    endfunction

    function automatic logic [31:0] rnd_f32(input int centre);
        int e = centre - 20 + int'($urandom_range(25));
        if (e < 1) e = 1;
        if (e > 254) e = 254;
        return mkf(1'($urandom), e, 23'($urandom));
    endfunction

    task automatic fill_random(input int centre);
        for (int i = 0; i < NGRP; i++) blk[i] = rnd_f32(centre);
    endtask

    // Drives one group; the last flag rides on the final word (R1)
    task automatic send_group(input int gap_max);
        for (int i = 0; i < NGRP; i++) begin
            int g = int'($urandom_range(gap_max));
            in_valid = 1'b0;
            repeat (g) begin @(posedge clk); #1; end
            in_valid = 1'b1;
            in_data  = blk[i];
            in_last  = (i == NGRP - 1);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        // R9: state during and after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R9 in_ready in reset", 32'(in_ready), 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R5: moderate random values, no stalls
        cur_tag = "R5"; stall_pct = 0;
        fill_random(130); send_group(0);

        // R4/R8: zeros, negative zero and subnormals
        for (int i = 0; i < NGRP; i++)
            blk[i] = (i % 3 == 0) ? 32'h8000_0000 : (i % 3 == 1) ? 32'h0 : mkf(1'($urandom), 0, 23'($urandom));
        cur_tag = "R8"; send_group(1);

        // R7: a NaN inside, then an infinity inside
        fill_random(120); blk[5] = 32'h7FC0_0000; cur_tag = "R7"; send_group(0);
        fill_random(120); blk[31] = 32'hFF80_0000; send_group(0);

        // R6: maximum just below 448 rounds up to the top code
        fill_random(130); blk[9] = mkf(0, 135, 23'h5FFFFF); cur_tag = "R6"; send_group(0);

        // R8/R5: maximum exactly -448 with rounding ties and tiny results
        fill_random(125);
        blk[0] = mkf(1, 135, 23'h600000);
        blk[1] = mkf(0, 127, 23'h080000);
        blk[2] = mkf(0, 127, 23'h180000);
        blk[3] = mkf(0, 118, 23'h400000);
        blk[4] = mkf(1, 119, 23'h200000);
        blk[5] = mkf(0, 117, 23'h000000);
        blk[6] = mkf(1, 115, 23'h000000);
        cur_tag = "R8"; send_group(0);

        // R3: fraction just above that of 1.75, and a clamped tiny group
        fill_random(130); blk[17] = mkf(0, 136, 23'h600001); cur_tag = "R3"; send_group(0);
        for (int i = 0; i < NGRP; i++) blk[i] = mkf(1'($urandom), 1 + int'($urandom_range(2)), 23'($urandom));
        send_group(0);

        // R2: random groups under back-pressure and input gaps
        cur_tag = "R2"; stall_pct = 40;
        for (int n = 0; n < 12; n++) begin
            fill_random(10 + int'($urandom_range(235)));
            send_group(2);
        end
        drain();

        // R9: reset in the middle of draining a group
        stall_pct = 100; cur_tag = "R5";
        fill_random(128); send_group(0);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after mid reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R9 in_ready after mid reset", 32'(in_ready), 32'd1);
        @(posedge clk); #1 rst_n = 1'b1;
        stall_pct = 10;
        fill_random(140); send_group(1);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule